// File: doc/BRIEF.md
# Power-Up Strap Capture and Factory Test Controller

This block samples the board configuration straps once, at the moment the active-low power-good input first reads low, and holds them for the rest of the power session. The captured values are three frequency-select bits, which are read back, and a selector that makes a shared differential pair serve either as an extra CPU pair or as SRC pair 7. The three-level test-select pin reaches this block already decoded to one logic level. When that level is high at capture, the most significant frequency-select bit is not taken from the pin, because the pin is used for test-select instead.

The block also controls a factory test mode. Test mode starts from the captured test-select strap or from a register bit that software writes after power is good. In test mode every clock output is either tri-stated or driven with the reference clock divided by `DIV_N`. Which input makes that choice depends on how test mode was entered. After strap entry the live test-mode pin decides. After register entry only a second register bit decides. Test mode, once entered, stays active until the power-on reset input is asserted.

All logic runs on the reference clock. The power-on reset asserts asynchronously and is released through a two-stage synchroniser.

Top module: `strap_test_ctrl`

## Requirements
- R1: While `por_n` is low, every output is 0: `fs_readback`=0, `pair_is_cpu`=0, `test_active`=0, `outputs_hiz`=0, `refdiv_clk`=0.
- R2: The straps are captured on the first functional clock edge at which `pwrgd_n` is 0. After that, changes on the strap pins and on `pwrgd_n` do not affect any output until the next `por_n` assertion.
- R3: `fs_readback[1:0]` shows the captured `strap_fs[1:0]`. `fs_readback[2]` shows the captured `strap_fs[2]` when `strap_tsel` was 0 at capture, and shows 0 when it was 1.
- R4: `pair_is_cpu` shows the captured `strap_pair` (1 = third CPU pair, 0 = SRC pair 7).
- R5: If `strap_tsel` was 1 at capture, `test_active` is 1 from the capturing edge onward. With no register entry, `tmode_pin`=0 gives `outputs_hiz`=1, and `tmode_pin`=1 gives the divided clock on `refdiv_clk`. The pin acts combinationally, with no clock delay.
- R6: `reg_test_enter`=1 at an edge that follows capture sets test mode, and `test_active` is 1 after that edge. While the straps are not yet captured, `reg_test_enter` is ignored.
- R7: After register entry, `reg_test_refn` alone picks the mode (0 = Hi-Z, 1 = divided clock), even if strap entry also happened, and `tmode_pin` has no effect.
- R8: Test mode is sticky. Clearing `reg_test_enter` or raising `pwrgd_n` does not clear `test_active`. Only `por_n` clears it.
- R9: In divided-clock mode, `refdiv_clk` has a period of `DIV_N` reference cycles and is high for `DIV_N/2` of them. Outside that mode it is 0, and `outputs_hiz` and `refdiv_clk` are never 1 together.
- R10: After `por_n` rises, the first two clock edges are still treated as reset. The third edge is the first functional one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pwrgd_n | input | 1 | Power good, active low; first low level triggers capture |
| strap_fs | input | 3 | Frequency-select strap pins |
| strap_tsel | input | 1 | Decoded test-select level |
| strap_pair | input | 1 | Shared pair role strap |
| tmode_pin | input | 1 | Real-time test-mode pin |
| reg_test_enter | input | 1 | Register bit: enter test mode |
| reg_test_refn | input | 1 | Register bit: mode choice after register entry |
| fs_readback | output | 3 | Captured frequency-select bits |
| pair_is_cpu | output | 1 | Captured pair role |
| test_active | output | 1 | Sticky test-mode flag |
| outputs_hiz | output | 1 | Tri-state command for all clock outputs |
| refdiv_clk | output | 1 | Reference divided by DIV_N in test mode |

## Verification
Two situations are hard to reach from the ports. The first is the overlap of both entry paths, where the register must take the mode choice away from the live pin after strap entry has already made the pin active. The bench reaches it by powering up with the test-select strap high, toggling the pin, and then writing the register bits with the pin held at the opposite value. The second is a register write that arrives before capture, and the write after capture that must still count. The bench reaches these by holding power-good inactive across several register writes in a second power session, and by proving stickiness with power-good deasserted again.

// File: rtl/strap_tm_pkg.sv
package strap_tm_pkg;
  localparam int FS_W = 3;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            pair_cpu;
    logic            test_sel;
  } strap_t;

  typedef enum logic {
    TM_HIZ  = 1'b0,
    TM_REFN = 1'b1
  } tmode_e;
endpackage

// File: rtl/por_sync.sv
module por_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;

  // R10: release walks through the first stage
  p_release_order_r10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(s2_q) |-> $past(s1_q));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_tm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwrgd_n,
  input  strap_t pins_i,
  output logic   captured_o,
  output strap_t held_o
);
  logic   cap_q, cap_d;
  strap_t held_q, held_d;

  always_comb begin
    cap_d  = cap_q;
    held_d = held_q;
    if (!cap_q && !pwrgd_n) begin
      cap_d           = 1'b1;
      held_d          = pins_i;
      held_d.fs[FS_W-1] = pins_i.test_sel ? 1'b0 : pins_i.fs[FS_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      held_q <= '0;
    end else begin
      cap_q  <= cap_d;
      held_q <= held_d;
    end
  end

  assign captured_o = cap_q;
  assign held_o     = held_q;

  p_capture_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> cap_q);
  p_held_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(held_q));
  p_fs_top_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    held_q.test_sel |-> (held_q.fs[FS_W-1] == 1'b0));
  p_no_capture_when_good_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_q && pwrgd_n) |=> !cap_q);
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int DIV_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);
  localparam int HALF = DIV_N / 2;
  localparam int CW   = (DIV_N > 2) ? $clog2(DIV_N) : 1;

  logic phase_q, phase_d;

  generate
    if (DIV_N == 2) begin : g_toggle
      always_comb phase_d = ~phase_q;
    end else begin : g_count
      localparam logic [CW-1:0] LAST  = CW'(DIV_N - 1);
      localparam logic [CW-1:0] HALFV = CW'(HALF);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        phase_d = (cnt_d < HALFV);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
      p_phase_rise_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q) |-> (cnt_q == '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b1;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
  import strap_tm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic captured_i,
  input  logic strap_test_i,
  input  logic tmode_pin_i,
  input  logic reg_enter_i,
  input  logic reg_refn_i,
  input  logic phase_i,
  output logic active_o,
  output logic hiz_o,
  output logic refdiv_o
);
  logic   sw_q, sw_d;
  tmode_e mode;

  always_comb begin
    sw_d = sw_q;
    if (captured_i && reg_enter_i) sw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_d;
  end

  always_comb begin
    if (sw_q) mode = reg_refn_i  ? TM_REFN : TM_HIZ;
    else      mode = tmode_pin_i ? TM_REFN : TM_HIZ;
  end

  assign active_o = strap_test_i | sw_q;
  assign hiz_o    = active_o && (mode == TM_HIZ);
  assign refdiv_o = active_o && (mode == TM_REFN) && phase_i;

  p_active_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> active_o);
  p_sw_after_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_q) |-> $past(captured_i));
  p_outputs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiz_o && refdiv_o));
  p_reg_owns_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q && !reg_refn_i) |-> (hiz_o && !refdiv_o));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (!hiz_o && !refdiv_o));
endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
  import strap_tm_pkg::*;
#(
  parameter int DIV_N = 4
) (
  input  logic            ref_clk,
  input  logic            por_n,
  input  logic            pwrgd_n,
  input  logic [FS_W-1:0] strap_fs,
  input  logic            strap_tsel,
  input  logic            strap_pair,
  input  logic            tmode_pin,
  input  logic            reg_test_enter,
  input  logic            reg_test_refn,
  output logic [FS_W-1:0] fs_readback,
  output logic            pair_is_cpu,
  output logic            test_active,
  output logic            outputs_hiz,
  output logic            refdiv_clk
);
  logic   rst_n;
  logic   captured;
  logic   phase;
  strap_t pins;
  strap_t held;

  assign pins.fs       = strap_fs;
  assign pins.pair_cpu = strap_pair;
  assign pins.test_sel = strap_tsel;

  por_sync u_sync (
    .clk    (ref_clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  strap_capture u_cap (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .pwrgd_n    (pwrgd_n),
    .pins_i     (pins),
    .captured_o (captured),
    .held_o     (held)
  );

  ref_divider #(.DIV_N(DIV_N)) u_div (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  test_mode_ctrl u_tm (
    .clk          (ref_clk),
    .rst_n        (rst_n),
    .captured_i   (captured),
    .strap_test_i (held.test_sel),
    .tmode_pin_i  (tmode_pin),
    .reg_enter_i  (reg_test_enter),
    .reg_refn_i   (reg_test_refn),
    .phase_i      (phase),
    .active_o     (test_active),
    .hiz_o        (outputs_hiz),
    .refdiv_o     (refdiv_clk)
  );

  assign fs_readback = held.fs;
  assign pair_is_cpu = held.pair_cpu;

  // R1: everything quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge ref_clk)
    !rst_n |-> (!test_active && !outputs_hiz && !refdiv_clk && fs_readback == '0));
endmodule

// File: tb/sim_strap_test_ctrl.sv
module sim_strap_test_ctrl;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       por_n, pwrgd_n, strap_tsel, strap_pair, tmode_pin;
  logic       reg_test_enter, reg_test_refn;
  logic [2:0] strap_fs;
  logic [2:0] fs_readback;
  logic       pair_is_cpu, test_active, outputs_hiz, refdiv_clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string req    = "R1";

  always #10 clk = ~clk;

  strap_test_ctrl #(.DIV_N(DIV)) u0 (
    .ref_clk(clk), .por_n(por_n), .pwrgd_n(pwrgd_n), .strap_fs(strap_fs),
    .strap_tsel(strap_tsel), .strap_pair(strap_pair), .tmode_pin(tmode_pin),
    .reg_test_enter(reg_test_enter), .reg_test_refn(reg_test_refn),
    .fs_readback(fs_readback), .pair_is_cpu(pair_is_cpu), .test_active(test_active),
    .outputs_hiz(outputs_hiz), .refdiv_clk(refdiv_clk)
  );

  // behavioural reference model
  bit       m_s1, m_s2, m_cap, m_tsel, m_pair, m_sw;
  bit [2:0] m_fs;
  int       m_cnt;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s1 <= 0; m_s2 <= 0; m_cap <= 0; m_tsel <= 0; m_pair <= 0;
      m_sw <= 0; m_fs <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= 1; m_s2 <= m_s1;
      if (m_s2) begin
        if (!m_cap && !pwrgd_n) begin
          m_cap  <= 1;
          m_fs   <= {strap_tsel ? 1'b0 : strap_fs[2], strap_fs[1:0]};
          m_pair <= strap_pair;
          m_tsel <= strap_tsel;
        end
        if (m_cap && reg_test_enter) m_sw <= 1;
        m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit act, sel, e_hiz, e_div;
    act   = m_tsel | m_sw;
    sel   = m_sw ? reg_test_refn : tmode_pin;
    e_hiz = act & ~sel;
    e_div = act & sel & (m_cnt < HALF);
    chk(fs_readback == m_fs, "fs_readback", fs_readback, m_fs);
    chk(pair_is_cpu == m_pair, "pair_is_cpu", pair_is_cpu, m_pair);
    chk(test_active == act, "test_active", test_active, act);
    chk(outputs_hiz == e_hiz, "outputs_hiz", outputs_hiz, e_hiz);
    chk(refdiv_clk == e_div, "refdiv_clk", refdiv_clk, e_div);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic count_high(int exp);
    int highs = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      tick();
      if (refdiv_clk) highs++;
    end
    chk(highs == exp, "refdiv high cycles in two periods", highs, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 0; pwrgd_n = 1; strap_fs = 3'b000; strap_tsel = 0; strap_pair = 0;
    tmode_pin = 0; reg_test_enter = 0; reg_test_refn = 0;

    // R1 reset state
    req = "R1";
    run(3);
    chk({fs_readback, pair_is_cpu, test_active, outputs_hiz, refdiv_clk} == 7'd0,
        "R1 all outputs zero", test_active, 0);

    // R10 release latency, with strap test entry pending at release
    strap_fs = 3'b111; strap_tsel = 1; strap_pair = 0; pwrgd_n = 0;
    por_n = 1;
    req = "R10";
    tick(); chk(test_active == 0, "R10 edge 1 still reset", test_active, 0);
    tick(); chk(test_active == 0, "R10 edge 2 still reset", test_active, 0);
    tick(); chk(test_active == 1, "R10 edge 3 captures", test_active, 1);

    req = "R3";
    chk(fs_readback == 3'b011, "R3 top fs bit masked by test select", fs_readback, 3);

    // R5 strap entry: live pin picks the mode
    req = "R5";
    tick(); chk(outputs_hiz == 1, "R5 pin low gives Hi-Z", outputs_hiz, 1);
    tmode_pin = 1;
    #1 chk(outputs_hiz == 0, "R5 pin acts without clock", outputs_hiz, 0);
    req = "R9";
    count_high(2 * HALF);
    req = "R5";
    tmode_pin = 0;
    run(2);

    // R7 register entry overrides the pin after strap entry
    req = "R7";
    reg_test_enter = 1; reg_test_refn = 0; tmode_pin = 1;
    tick(); tick();
    chk(outputs_hiz == 1, "R7 register Hi-Z with pin high", outputs_hiz, 1);
    for (int i = 0; i < DIV; i++) begin
      tmode_pin = i[0];
      tick();
      chk(refdiv_clk == 0, "R7 pin ignored, no divided clock", refdiv_clk, 0);
    end

    // R8 sticky against register clear and power-good loss
    req = "R8";
    reg_test_enter = 0; pwrgd_n = 1;
    run(4);
    chk(test_active == 1, "R8 still active", test_active, 1);

    // second power session
    req = "R1";
    por_n = 0;
    tick();
    chk(test_active == 0 && fs_readback == 0, "R1 power cycle clears", test_active, 0);
    strap_fs = 3'b101; strap_tsel = 0; strap_pair = 1; tmode_pin = 0;
    por_n = 1;
    req = "R6";
    reg_test_enter = 1; reg_test_refn = 1;
    run(6);
    chk(test_active == 0, "R6 write before capture ignored", test_active, 0);
    reg_test_enter = 0;

    req = "R2";
    pwrgd_n = 0;
    run(2);
    strap_fs = 3'b010; strap_tsel = 1; strap_pair = 0;
    pwrgd_n = 1; tick(); pwrgd_n = 0;
    run(4);
    chk(fs_readback == 3'b101, "R2 straps frozen after capture", fs_readback, 5);
    chk(test_active == 0, "R2 late test select ignored", test_active, 0);
    req = "R3";
    chk(fs_readback[2] == 1, "R3 top fs bit kept with test select low", fs_readback[2], 1);
    req = "R4";
    chk(pair_is_cpu == 1, "R4 pair role latched", pair_is_cpu, 1);

    req = "R6";
    reg_test_enter = 1; reg_test_refn = 1;
    tick(); tick();
    chk(test_active == 1, "R6 write after capture enters", test_active, 1);

    req = "R7";
    tmode_pin = 0;
    count_high(2 * HALF);
    tmode_pin = 1; reg_test_refn = 0;
    tick();
    chk(outputs_hiz == 1, "R7 register picks Hi-Z", outputs_hiz, 1);

    req = "R8";
    reg_test_enter = 0;
    run(4);
    chk(test_active == 1, "R8 clearing register keeps test", test_active, 1);

    req = "R9";
    reg_test_refn = 1;
    count_high(2 * HALF);

    done = 1;
    summary();
    $finish;
  end
endmodule